// File: doc/BRIEF.md
# Iterative 32x32 Multiply-Accumulate Unit

This block multiplies two 32-bit operands over several clock cycles. It supports six operations. Two short forms return a 32-bit word: the bare product, or the product plus a 32-bit addend. Four long forms return a 64-bit value as a high word and a low word: an unsigned or signed product, or that product added to a 64-bit accumulator pair supplied on the inputs. The block has no register file and no instruction decoder. The caller presents the operands and the operation code together with a one-cycle start pulse, then waits for a one-cycle done pulse. The result words and the two condition flags stay on the outputs until the next operation completes.

The datapath is a radix-4 shift-add engine that retires two multiplier bits per cycle. It works on operand magnitudes and negates the product afterwards for the signed long forms. A final stage applies the sign, adds the accumulator and updates the flags. An accepted start produces done exactly 17 cycles later.

Top module: `mac_unit`

## Requirements
- R1: After synchronous reset, busy, done, both result words, flag_n and flag_z are all 0.
- R2: Operation code 0 (plain short product) returns the low 32 bits of opnd_a*opnd_b on res_lo, with res_hi = 0.
- R3: Operation code 1 (short multiply-add) returns (opnd_a*opnd_b + addend) mod 2^32 on res_lo, with res_hi = 0.
- R4: Operation code 2 (unsigned long) returns the full unsigned 64-bit product as {res_hi, res_lo}; for example 0xF0000002 times 0x00000002 gives res_hi = 0x00000001 and res_lo = 0xE0000004.
- R5: Operation code 4 (signed long) returns the two's-complement 64-bit product of the signed operands as {res_hi, res_lo}.
- R6: Operation codes 3 (unsigned) and 5 (signed) return (long product + {acc_hi, acc_lo}) mod 2^64 as {res_hi, res_lo}.
- R7: A start that arrives while busy is 0 is accepted. busy is then 1 for the 17 cycles that follow. done is 1 for exactly one cycle, 17 clock edges after the accepting edge, and busy is 0 in that cycle.
- R8: A start that arrives while busy is 1 is ignored, and so are changes on any operand or control input during that time. The result reflects only the values sampled with the accepted start.
- R9: When set_flags was 1 at the accepted start, the flags are updated in the done cycle. flag_n is bit 31 of res_lo (short forms) or bit 63 of the 64-bit result (long forms). flag_z is 1 when the whole result is zero: 32 bits for short forms, 64 bits for long forms.
- R10: When set_flags was 0 at the accepted start, flag_n and flag_z keep their previous values. The flags never change outside a done cycle.
- R11: res_hi and res_lo change only in a done cycle and hold their values between done pulses.
- R12: Operation codes 6 and 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while busy is 0 |
| op | input | 3 | Operation code: 0 mul, 1 mul-add, 2 unsigned long, 3 unsigned long acc, 4 signed long, 5 signed long acc |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| addend | input | 32 | Addend for the short multiply-add |
| acc_hi | input | 32 | High word of the accumulator pair |
| acc_lo | input | 32 | Low word of the accumulator pair |
| set_flags | input | 1 | Update flag_n and flag_z on completion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 32 | High result word (0 for short forms) |
| res_lo | output | 32 | Low result word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
Corruption in the iteration counter shows up as done arriving early or late, or busy dropping early. The per-cycle comparison against the behavioural model catches this at the first wrong edge. A fault in the partial-product selection, the magnitude conversion or the final negation leaves the cycle timing intact, but the result words are wrong in the done cycle of that operation. The bench therefore uses operands whose multiplier digits cover all four radix-4 values, and it includes both sign combinations and the most negative operand. A latched control field that is lost or overwritten while busy shows up at the next done, as a wrong operation, addend, accumulator or flag update.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned MAC_W   = 32;
    localparam int unsigned MAC_DW  = 2 * MAC_W;
    localparam int unsigned MAC_LAT = MAC_W / 2 + 1;

    typedef enum logic [2:0] {
        OP_MUL   = 3'd0,
        OP_MLA   = 3'd1,
        OP_UMULL = 3'd2,
        OP_UMLAL = 3'd3,
        OP_SMULL = 3'd4,
        OP_SMLAL = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } mac_op_e;

    typedef struct packed {
        mac_op_e             op;
        logic                negate;
        logic                set_flags;
        logic [MAC_W-1:0]    addend;
        logic [MAC_DW-1:0]   acc;
    } mac_ctl_t;

    typedef struct packed {
        logic [MAC_W-1:0] hi;
        logic [MAC_W-1:0] lo;
        logic             n;
        logic             z;
    } mac_res_t;

    function automatic logic op_is_signed(input mac_op_e op);
        return (op == OP_SMULL) || (op == OP_SMLAL);
    endfunction

    function automatic logic op_is_long(input mac_op_e op);
        return (op == OP_UMULL) || (op == OP_UMLAL) ||
               (op == OP_SMULL) || (op == OP_SMLAL);
    endfunction

    function automatic logic op_is_long_acc(input mac_op_e op);
        return (op == OP_UMLAL) || (op == OP_SMLAL);
    endfunction

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
    import mac_pkg::*;
#(
    parameter int unsigned W = MAC_W
) (
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         negate_o
);
    logic sgn;
    logic neg_a;
    logic neg_b;

    always_comb begin
        sgn      = op_is_signed(mac_op_e'(op_i));
        neg_a    = sgn & a_i[W-1];
        neg_b    = sgn & b_i[W-1];
        mag_a_o  = neg_a ? (~a_i + 1'b1) : a_i;
        mag_b_o  = neg_b ? (~b_i + 1'b1) : b_i;
        negate_o = neg_a ^ neg_b;
    end
endmodule

// File: rtl/mac_radix4_core.sv
module mac_radix4_core #(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [W-1:0]   mag_a_i,
    input  logic [W-1:0]   mag_b_i,
    output logic [2*W-1:0] prod_o,
    output logic           running_o,
    output logic           fin_o
);
    localparam int unsigned DW   = 2 * W;
    localparam int unsigned ITER = W / 2;
    localparam int unsigned CW   = $clog2(ITER + 1);

    logic [DW-1:0] mcand;
    logic [W-1:0]  mplier;
    logic [DW-1:0] sum;
    logic [DW-1:0] pp;
    logic [CW-1:0] cnt;
    logic          running;
    logic          fin;

    always_comb begin
        case (mplier[1:0])
            2'd0:    pp = '0;
            2'd1:    pp = mcand;
            2'd2:    pp = mcand << 1;
            default: pp = mcand + (mcand << 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand   <= '0;
            mplier  <= '0;
            sum     <= '0;
            cnt     <= '0;
            running <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load_i) begin
                mcand   <= {{W{1'b0}}, mag_a_i};
                mplier  <= mag_b_i;
                sum     <= '0;
                cnt     <= '0;
                running <= 1'b1;
            end else if (running) begin
                sum    <= sum + pp;
                mcand  <= mcand << 2;
                mplier <= mplier >> 2;
                cnt    <= cnt + 1'b1;
                if (cnt == CW'(ITER - 1)) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
        end
    end

    assign prod_o    = sum;
    assign running_o = running;
    assign fin_o     = fin;
endmodule

// File: rtl/mac_result_stage.sv
module mac_result_stage
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fin_i,
    input  logic [MAC_DW-1:0] prod_i,
    input  mac_ctl_t          ctl_i,
    output logic              done_o,
    output mac_res_t          res_o
);
    logic [MAC_DW-1:0] sprod;
    logic [MAC_DW-1:0] full;
    logic [MAC_W-1:0]  short_lo;
    mac_res_t          nxt;

    always_comb begin
        sprod    = ctl_i.negate ? (~prod_i + 1'b1) : prod_i;
        short_lo = sprod[MAC_W-1:0];
        if (ctl_i.op == OP_MLA) begin
            short_lo = sprod[MAC_W-1:0] + ctl_i.addend;
        end
        full = op_is_long_acc(ctl_i.op) ? (sprod + ctl_i.acc) : sprod;

        nxt = res_o;
        if (op_is_long(ctl_i.op)) begin
            nxt.hi = full[MAC_DW-1:MAC_W];
            nxt.lo = full[MAC_W-1:0];
            if (ctl_i.set_flags) begin
                nxt.n = full[MAC_DW-1];
                nxt.z = (full == '0);
            end
        end else begin
            nxt.hi = '0;
            nxt.lo = short_lo;
            if (ctl_i.set_flags) begin
                nxt.n = short_lo[MAC_W-1];
                nxt.z = (short_lo == '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            res_o  <= '0;
        end else begin
            done_o <= fin_i;
            if (fin_i) begin
                res_o <= nxt;
            end
        end
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  op,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [31:0] addend,
    input  logic [31:0] acc_hi,
    input  logic [31:0] acc_lo,
    input  logic        set_flags,
    output logic        busy,
    output logic        done,
    output logic [31:0] res_hi,
    output logic [31:0] res_lo,
    output logic        flag_n,
    output logic        flag_z
);
    logic [MAC_W-1:0]  mag_a;
    logic [MAC_W-1:0]  mag_b;
    logic              negate;
    logic [MAC_DW-1:0] prod;
    logic              running;
    logic              fin;
    logic              accept;
    mac_ctl_t          ctl_q;
    mac_res_t          res;

    assign busy   = running | fin;
    assign accept = start & ~busy;

    mac_operand_prep #(.W(MAC_W)) u_prep (
        .op_i     (op),
        .a_i      (opnd_a),
        .b_i      (opnd_b),
        .mag_a_o  (mag_a),
        .mag_b_o  (mag_b),
        .negate_o (negate)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (accept) begin
            ctl_q.op        <= mac_op_e'(op);
            ctl_q.negate    <= negate;
            ctl_q.set_flags <= set_flags;
            ctl_q.addend    <= addend;
            ctl_q.acc       <= {acc_hi, acc_lo};
        end
    end

    mac_radix4_core #(.W(MAC_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load_i    (accept),
        .mag_a_i   (mag_a),
        .mag_b_i   (mag_b),
        .prod_o    (prod),
        .running_o (running),
        .fin_o     (fin)
    );

    mac_result_stage u_res (
        .clk    (clk),
        .rst    (rst),
        .fin_i  (fin),
        .prod_i (prod),
        .ctl_i  (ctl_q),
        .done_o (done),
        .res_o  (res)
    );

    assign res_hi = res.hi;
    assign res_lo = res.lo;
    assign flag_n = res.n;
    assign flag_z = res.z;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int unsigned LAT = mac_pkg::MAC_LAT
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] res_hi,
    input logic [31:0] res_lo,
    input logic        flag_n,
    input logic        flag_z
);
    logic [7:0] cnt;
    logic       trk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            trk <= 1'b0;
        end else if (start && !busy) begin
            cnt <= '0;
            trk <= 1'b1;
        end else if (done) begin
            trk <= 1'b0;
        end else if (trk) begin
            cnt <= cnt + 8'd1;
        end
    end

    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && res_hi == 32'd0 && res_lo == 32'd0 && !flag_n && !flag_z));

    // R7
    a_r7_done_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (trk && cnt == 8'(LAT)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_busy_starts: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r7_busy_done_apart: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R8
    a_r8_busy_uninterrupted: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != 8'(LAT - 1)) |=> busy);

    // R11
    a_r11_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_hi) && $stable(res_lo)));

    // R10
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(flag_n) && $stable(flag_z)));
endmodule

bind mac_unit mac_unit_chk #(.LAT(mac_pkg::MAC_LAT)) u_mac_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .res_hi (res_hi),
    .res_lo (res_lo),
    .flag_n (flag_n),
    .flag_z (flag_z)
);

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
module mac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0, addend = '0, acc_hi = '0, acc_lo = '0;
    logic        set_flags = 1'b0;
    logic        busy, done, flag_n, flag_z;
    logic [31:0] res_hi, res_lo;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mac_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .addend(addend),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .set_flags(set_flags),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    // Behavioural reference model
    bit          m_busy, m_done, m_n, m_z;
    int          m_cnt;
    logic [31:0] m_hi, m_lo;
    logic [31:0] p_hi, p_lo;
    bit          p_n, p_z, p_sf;
    string       p_tag;
    string       phase = "";

    task automatic model_accept();
        logic [63:0] pu, ps, full;
        bit long_f;
        pu = {32'd0, opnd_a} * {32'd0, opnd_b};
        ps = 64'($signed({{32{opnd_a[31]}}, opnd_a}) * $signed({{32{opnd_b[31]}}, opnd_b}));
        long_f = 1'b0;
        case (op)
            3'd1: begin full = {32'd0, pu[31:0] + addend}; p_tag = "R3"; end
            3'd2: begin full = pu; long_f = 1'b1; p_tag = "R4"; end
            3'd3: begin full = pu + {acc_hi, acc_lo}; long_f = 1'b1; p_tag = "R6"; end
            3'd4: begin full = ps; long_f = 1'b1; p_tag = "R5"; end
            3'd5: begin full = ps + {acc_hi, acc_lo}; long_f = 1'b1; p_tag = "R6"; end
            3'd0: begin full = {32'd0, pu[31:0]}; p_tag = "R2"; end
            default: begin full = {32'd0, pu[31:0]}; p_tag = "R12"; end
        endcase
        if (phase != "") p_tag = phase;
        p_hi = full[63:32];
        p_lo = full[31:0];
        p_sf = set_flags;
        p_n  = long_f ? full[63] : full[31];
        p_z  = long_f ? (full == 64'd0) : (full[31:0] == 32'd0);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            m_hi = '0; m_lo = '0; m_n = 0; m_z = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 17) begin
                    m_busy = 0;
                    m_done = 1;
                    m_hi = p_hi;
                    m_lo = p_lo;
                    if (p_sf) begin m_n = p_n; m_z = p_z; end
                end
            end else if (start) begin
                model_accept();
                m_busy = 1;
                m_cnt  = 0;
            end
        end
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R7", "busy", 64'(busy), 64'(m_busy));
            chk("R7", "done", 64'(done), 64'(m_done));
            chk(m_done ? p_tag : "R11", "result", {res_hi, res_lo}, {m_hi, m_lo});
            chk((m_done && p_sf) ? "R9" : "R10", "flags", 64'({flag_n, flag_z}), 64'({m_n, m_z}));
        end
    end

    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] ad, input logic [31:0] h, input logic [31:0] l,
                          input bit sf);
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; addend = ad; acc_hi = h; acc_lo = l;
        set_flags = sf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset state", {busy, done, flag_n, flag_z, 28'd0, res_lo | res_hi}, 64'd0);

        run_op(3'd0, 32'd2, 32'd2, 0, 0, 0, 1);                         // R2
        run_op(3'd0, 32'h0001_0000, 32'h0001_0000, 0, 0, 0, 1);         // R2 zero low word, R9 short Z
        run_op(3'd1, 32'd7, 32'd9, 32'hFFFF_FFF0, 0, 0, 1);             // R3 wrap
        run_op(3'd2, 32'hF000_0002, 32'h0000_0002, 0, 0, 0, 1);         // R4 example
        run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 1);         // R4 max
        run_op(3'd2, 32'h0001_0000, 32'h0001_0000, 0, 0, 0, 1);         // R9 long Z clear
        run_op(3'd4, 32'hFFFF_FFFD, 32'd5, 0, 0, 0, 1);                 // R5 negative, N set
        run_op(3'd4, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 1);         // R5 most negative
        run_op(3'd4, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, 0);         // R10 flags held
        run_op(3'd3, 32'hFFFF_FFFF, 32'd2, 0, 32'hFFFF_FFFF, 32'h0000_0003, 1); // R6 wrap
        run_op(3'd5, 32'hFFFF_FFFF, 32'd1, 0, 32'd0, 32'd1, 1);         // R6 signed to zero
        run_op(3'd6, 32'h1234_5678, 32'h9ABC_DEF0, 32'hFF, 32'h11, 32'h22, 1); // R12
        run_op(3'd7, 32'hCAFE_0001, 32'h0000_0003, 32'hFF, 0, 0, 1);    // R12

        // R8: start and inputs change while busy
        phase = "R8";
        @(negedge clk);
        op = 3'd2; opnd_a = 32'd3; opnd_b = 32'd5; set_flags = 1'b1; start = 1'b1;
        @(negedge clk);
        op = 3'd1; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF; addend = 32'h55; set_flags = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        phase = "";

        for (int i = 0; i < 20; i++) begin
            run_op(3'($urandom_range(0, 7)), $urandom, $urandom, $urandom,
                   $urandom, $urandom, bit'($urandom_range(0, 1)));
        end
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule